// File: doc/BRIEF.md
# Tuner Control Two-Wire Slave

This block is the serial control port for a tuner's nine-entry configuration bank. It oversamples the two-wire bus lines (serial clock and serial data) with a fast system clock, detects START and STOP conditions, and acts as an open-drain slave. The device answers a 7-bit address whose upper five bits are fixed and whose two low bits come from strap pins.

A write transaction delivers a register-index byte and then any number of data bytes. Each data byte lands in the next register in sequence, and every byte is acknowledged. A read transaction carries no index. It always returns one status byte assembled from the loop lock flags, the tuning-range flags and the power-on-reset flag. The nine stored registers are presented as one flat vector to the rest of the chip.

The data line is never driven high: `sda_oe` high means "pull SDA low". Clock stretching, general call and 10-bit addressing are not supported.

Top module: `tuner_i2c_slave`

## Requirements
- R1: After reset every configuration register reads 0x00 and `sda_oe` is 0 (bus released).
- R2: The slave acknowledges (holds SDA low through the 9th clock) an address byte whose upper seven bits equal binary 11000 followed by `addr_sel[1]` then `addr_sel[0]`, so the write/read byte values are 0xC0/0xC1, 0xC2/0xC3, 0xC4/0xC5 and 0xC6/0xC7 for `addr_sel` 0..3; bit 0 selects read (1) or write (0).
- R3: A non-matching address byte is not acknowledged, and every later byte is ignored (no acknowledge, no register change) until the next START, even if it looks like a matching address.
- R4: In a write, the byte after the address is the register index and is acknowledged; the next data byte is stored into register `cfg_regs[8*idx +: 8]` for index 0..8 and acknowledged. Storage happens while SCL is low after the byte's 8th bit.
- R5: Each further data byte in the same write goes to the next higher register index (auto-increment) and is acknowledged.
- R6: A register index above 8 (including any byte with a nonzero upper nibble), or an auto-increment past index 8, leaves data bytes acknowledged but discarded; registers 0..8 are unchanged by them.
- R7: A read returns one byte, MSB first: bit 7 `lock_a`, bit 6 `lock_b`, bit 5 `por_done`, bit 4 `range_a`, bit 3 `range_b`, bits 2:0 read as 0. The flags are captured when the address acknowledge ends.
- R8: After the read byte the slave releases SDA, regardless of the master's acknowledge bit. Further clocks before a START read 0xFF and do not disturb the registers.
- R9: A START at any point, including a repeated START mid-transaction or mid-byte, restarts address reception. A STOP returns the slave to idle with SDA released.
- R10: The slave changes `sda_oe` only while SCL is low (except the release that follows START or STOP).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| addr_sel | input | 2 | Strap pins for the two low address bits ([1] is the upper one) |
| lock_a | input | 1 | First loop locked |
| lock_b | input | 1 | Second loop locked |
| por_done | input | 1 | Power-on reset completed successfully |
| range_a | input | 1 | First loop tuning voltage over/under range |
| range_b | input | 1 | Second loop tuning voltage over/under range |
| cfg_regs | output | 72 | Register bank, register i at bits [8*i+7:8*i] |

## Verification
The bench aims at the places where a pointer or address decode goes wrong. It starts an auto-increment at index 7 so that it runs past 8: a design that wrapped would overwrite registers 0 and 1, and one that stopped acknowledging would show a NACK. It sends a matching address value after a mismatched one without a START between them; a slave that re-armed on any byte would acknowledge it. It reads past the status byte, checks a STOP in the middle of a byte, and writes across a repeated START. These cases expose a slave that keeps driving SDA or drops the register index. It also walks all four strap values and random status patterns, which catches swapped pin order or misplaced status bits.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

    localparam int NUM_REGS   = 9;
    localparam int REG_AW     = $clog2(NUM_REGS);
    localparam int BYTE_W     = 8;
    localparam logic [4:0] DEV_ADDR_HI = 5'b11000;
    localparam logic [7:0] PTR_SAT    = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_REG,
        ST_ACK_WR,
        ST_DATA,
        ST_READ,
        ST_SKIP
    } slv_state_e;

    typedef struct packed {
        slv_state_e        state;
        logic [2:0]        bit_cnt;
        logic              byte_done;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] ptr;
        logic              is_read;
        logic [BYTE_W-1:0] rd_sh;
        logic              drive;
        logic              wr_en;
        logic [REG_AW-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
    } eng_state_t;

endpackage

// File: rtl/tsl_bus_sync.sv
module tsl_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_d, scl_q;
    logic [DEPTH-1:0] sda_d, sda_q;
    logic             scl_s, scl_p, sda_p;

    always_comb begin
        scl_d = {scl_q[DEPTH-2:0], scl_i};
        sda_d = {sda_q[DEPTH-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    always_comb begin
        scl_s    = scl_q[STAGES-1];
        scl_p    = scl_q[STAGES];
        sda_s    = sda_q[STAGES-1];
        sda_p    = sda_q[STAGES];
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_ev = scl_s & scl_p & sda_p & ~sda_s;
        stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/tsl_engine.sv
module tsl_engine
    import tsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [1:0]        dev_pins,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_drive,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    eng_state_t s_d, s_q;
    logic       addr_hit;

    always_comb begin
        addr_hit = (s_q.shreg[7:1] == {DEV_ADDR_HI, dev_pins});
    end

    always_comb begin
        s_d       = s_q;
        s_d.wr_en = 1'b0;

        if (start_ev) begin
            s_d.state     = ST_DEV;
            s_d.bit_cnt   = '0;
            s_d.byte_done = 1'b0;
            s_d.drive     = 1'b0;
        end else if (stop_ev) begin
            s_d.state     = ST_IDLE;
            s_d.byte_done = 1'b0;
            s_d.drive     = 1'b0;
        end else begin
            unique case (s_q.state)
                ST_DEV, ST_REG, ST_DATA: begin
                    if (scl_rise) begin
                        s_d.shreg = {s_q.shreg[6:0], sda_s};
                        if (s_q.bit_cnt == 3'd7) s_d.byte_done = 1'b1;
                        else                     s_d.bit_cnt   = s_q.bit_cnt + 3'd1;
                    end else if (scl_fall && s_q.byte_done) begin
                        s_d.byte_done = 1'b0;
                        s_d.bit_cnt   = '0;
                        if (s_q.state == ST_DEV) begin
                            if (addr_hit) begin
                                s_d.drive   = 1'b1;
                                s_d.is_read = s_q.shreg[0];
                                s_d.state   = ST_ACK_DEV;
                            end else begin
                                s_d.state   = ST_SKIP;
                            end
                        end else if (s_q.state == ST_REG) begin
                            s_d.ptr   = s_q.shreg;
                            s_d.drive = 1'b1;
                            s_d.state = ST_ACK_WR;
                        end else begin
                            if (s_q.ptr < BYTE_W'(NUM_REGS)) begin
                                s_d.wr_en   = 1'b1;
                                s_d.wr_addr = s_q.ptr[REG_AW-1:0];
                                s_d.wr_data = s_q.shreg;
                            end
                            if (s_q.ptr != PTR_SAT) s_d.ptr = s_q.ptr + 8'd1;
                            s_d.drive = 1'b1;
                            s_d.state = ST_ACK_WR;
                        end
                    end
                end
                ST_ACK_DEV: begin
                    if (scl_fall) begin
                        if (s_q.is_read) begin
                            s_d.rd_sh   = status;
                            s_d.drive   = ~status[7];
                            s_d.bit_cnt = '0;
                            s_d.state   = ST_READ;
                        end else begin
                            s_d.drive   = 1'b0;
                            s_d.state   = ST_REG;
                        end
                    end
                end
                ST_ACK_WR: begin
                    if (scl_fall) begin
                        s_d.drive = 1'b0;
                        s_d.state = ST_DATA;
                    end
                end
                ST_READ: begin
                    if (scl_fall) begin
                        if (s_q.bit_cnt == 3'd7) begin
                            s_d.drive = 1'b0;
                            s_d.state = ST_SKIP;
                        end else begin
                            s_d.bit_cnt = s_q.bit_cnt + 3'd1;
                            s_d.rd_sh   = {s_q.rd_sh[6:0], 1'b0};
                            s_d.drive   = ~s_q.rd_sh[6];
                        end
                    end
                end
                default: begin
                    s_d.drive = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state     <= ST_IDLE;
            s_q.bit_cnt   <= '0;
            s_q.byte_done <= 1'b0;
            s_q.shreg     <= '0;
            s_q.ptr       <= '0;
            s_q.is_read   <= 1'b0;
            s_q.rd_sh     <= '0;
            s_q.drive     <= 1'b0;
            s_q.wr_en     <= 1'b0;
            s_q.wr_addr   <= '0;
            s_q.wr_data   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        sda_drive = s_q.drive;
        wr_en     = s_q.wr_en;
        wr_addr   = s_q.wr_addr;
        wr_data   = s_q.wr_data;
    end

endmodule

// File: rtl/tsl_reg_bank.sv
module tsl_reg_bank #(
    parameter int NREGS = 9,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NREGS*DW-1:0] regs_flat
);

    logic [DW-1:0] regs_d [NREGS];
    logic [DW-1:0] regs_q [NREGS];

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        always_comb begin
            regs_d[gi] = regs_q[gi];
            if (wr_en && (wr_addr == AW'(gi))) regs_d[gi] = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[gi] <= '0;
            else        regs_q[gi] <= regs_d[gi];
        end

        assign regs_flat[gi*DW +: DW] = regs_q[gi];
    end

endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
    import tsl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    input  logic [1:0]                 addr_sel,
    input  logic                       lock_a,
    input  logic                       lock_b,
    input  logic                       por_done,
    input  logic                       range_a,
    input  logic                       range_b,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);

    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              wr_en;
    logic [REG_AW-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] status;

    always_comb begin
        status = {lock_a, lock_b, por_done, range_a, range_b, 3'b000};
    end

    tsl_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    tsl_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .dev_pins  (addr_sel),
        .status    (status),
        .sda_drive (sda_oe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    tsl_reg_bank #(.NREGS(NUM_REGS), .AW(REG_AW), .DW(BYTE_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: rtl/tsl_checks.sv
module tsl_checks
    import tsl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr
);

    logic              have_last;
    logic [REG_AW-1:0] last_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            last_addr <= '0;
        end else if (start_ev) begin
            have_last <= 1'b0;
        end else if (wr_en) begin
            have_last <= 1'b1;
            last_addr <= wr_addr;
        end
    end

    assert_release_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_oe);

    assert_store_while_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_i);

    assert_consecutive_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && have_last && !start_ev) |-> (wr_addr == last_addr + REG_AW'(1)));

    assert_index_in_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < REG_AW'(NUM_REGS)));

    assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    assert_hold_while_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i, 1) && $past(scl_i, 2) && $past(scl_i, 3) &&
         $past(scl_i, 4) && $past(scl_i, 5) && !$past(start_ev) && !$past(stop_ev))
        |-> $stable(sda_oe));

endmodule

bind tuner_i2c_slave tsl_checks u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr)
);

// File: tb/sim_tuner_i2c_slave.sv
`timescale 1ns/1ps
module sim_tuner_i2c_slave;

    localparam int NR = 9;
    localparam int Q  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [1:0] addr_sel = 2'd0;
    logic lock_a = 0, lock_b = 0, por_done = 0, range_a = 0, range_b = 0;
    logic [NR*8-1:0] cfg_regs;

    int n_cmp = 0;
    int n_bad = 0;
    int r10_viol = 0;
    bit done = 0;
    logic [7:0] model [NR];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    tuner_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .lock_a(lock_a), .lock_b(lock_b), .por_done(por_done),
        .range_a(range_a), .range_b(range_b), .cfg_regs(cfg_regs)
    );

    logic scl_prev = 1'b1, oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_oe != oe_prev)) r10_viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {lock_a, lock_b, por_done, range_a, range_b, 3'b000};
    endfunction

    task automatic check_bank(string req);
        for (int i = 0; i < NR; i++) check(req, cfg_regs[i*8 +: 8], model[i]);
    endtask

    task automatic bus_start();
        sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
    endtask

    task automatic send_bit(logic b);
        sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    endtask

    task automatic send_byte(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1; tick(Q); scl_m = 1; tick(Q);
        acked = ~sda_line;
        tick(Q); scl_m = 0; tick(Q);
    endtask

    task automatic recv_byte(logic nack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 0;
        end
        tick(Q);
        send_bit(nack);
        sda_m = 1;
    endtask

    function automatic logic [7:0] dev_byte(logic [1:0] pins, logic rd);
        return {5'b11000, pins, rd};
    endfunction

    // write with model update; data[] bytes, len count
    task automatic write_txn(string req, logic [7:0] ra, int len, logic [7:0] d0, logic [7:0] d1,
                             logic [7:0] d2, logic [7:0] d3);
        logic a;
        int p;
        logic [7:0] db [4];
        db[0] = d0; db[1] = d1; db[2] = d2; db[3] = d3;
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b0), a); check({req, " R2 addr ack"}, a, 1);
        send_byte(ra, a); check({req, " R4 index ack"}, a, 1);
        p = ra;
        for (int k = 0; k < len; k++) begin
            send_byte(db[k], a); check({req, " data ack"}, a, 1);
            if (p < NR) model[p] = db[k];
            if (p < 255) p++;
        end
        bus_stop();
        tick(Q);
    endtask

    task automatic read_txn(string req);
        logic a;
        logic [7:0] b;
        logic [7:0] e;
        e = exp_status();
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b1), a); check({req, " R2 read addr ack"}, a, 1);
        recv_byte(1'b1, b); check({req, " R7 status"}, b, e);
        bus_stop();
        tick(Q);
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        for (int i = 0; i < NR; i++) model[i] = 8'h00;
        tick(5);
        check("R1 sda released in reset", sda_oe, 0);
        rst_n = 1;
        tick(5);
        check("R1 sda released", sda_oe, 0);
        check_bank("R1 reset value");

        // R2: all four strap settings, R4 single writes
        for (int pv = 0; pv < 4; pv++) begin
            addr_sel = 2'(pv);
            write_txn("R2/R4 strap", 8'(pv), 1, 8'hA0 + 8'(pv), 0, 0, 0);
            check_bank("R4 single write");
        end

        // R5: auto increment across whole bank
        addr_sel = 2'd2;
        write_txn("R5 burst", 8'h00, 4, 8'h11, 8'h22, 8'h33, 8'h44);
        write_txn("R5 burst", 8'h04, 4, 8'h55, 8'h66, 8'h77, 8'h88);
        check_bank("R5 auto increment");

        // R6: run past index 8, then out-of-range index
        write_txn("R6 overrun", 8'h07, 4, 8'hC7, 8'hC8, 8'hE1, 8'hE2);
        check_bank("R6 overrun discarded");
        write_txn("R6 index 0x20", 8'h20, 2, 8'h5A, 8'hA5, 0, 0);
        write_txn("R6 index 0x0B", 8'h0B, 1, 8'h3C, 0, 0, 0);
        check_bank("R6 out of range discarded");

        // R3: mismatch, then a matching-looking byte without START
        addr_sel = 2'd1;
        bus_start();
        send_byte(8'hC0, a); check("R3 mismatch nack", a, 0);
        send_byte(8'hC2, a); check("R3 no re-arm without START", a, 0);
        send_byte(8'h01, a); check("R3 ignored byte", a, 0);
        send_byte(8'hFF, a); check("R3 ignored byte", a, 0);
        bus_stop();
        tick(Q);
        check_bank("R3 bank untouched");
        check("R3 sda released", sda_oe, 0);

        // R7 / R8: status read, read past the byte
        lock_a = 1; lock_b = 0; por_done = 1; range_a = 0; range_b = 1;
        read_txn("R7 pattern A");
        lock_a = 0; lock_b = 1; por_done = 0; range_a = 1; range_b = 0;
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b1), a); check("R2 read ack", a, 1);
        recv_byte(1'b0, b); check("R7 pattern B", b, exp_status());
        recv_byte(1'b1, b); check("R8 released after byte", b, 8'hFF);
        bus_stop();
        tick(Q);
        check("R8 sda released", sda_oe, 0);
        check_bank("R8 bank untouched");

        // R9: repeated START mid-transaction
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b0), a);
        send_byte(8'h02, a);
        send_byte(8'h9E, a); model[2] = 8'h9E;
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b0), a); check("R9 repeated start ack", a, 1);
        send_byte(8'h05, a); check("R9 new index ack", a, 1);
        send_byte(8'h4D, a); model[5] = 8'h4D;
        bus_stop();
        tick(Q);
        check_bank("R9 repeated start");

        // R9: STOP in the middle of a byte, then normal write
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b0), a);
        send_byte(8'h06, a);
        send_bit(1); send_bit(0); send_bit(1);
        bus_stop();
        tick(Q);
        check("R9 idle after mid-byte stop", sda_oe, 0);
        check_bank("R9 partial byte dropped");
        write_txn("R9 after stop", 8'h06, 1, 8'h6B, 0, 0, 0);
        check_bank("R9 write after stop");

        // random mix
        for (int t = 0; t < 24; t++) begin
            addr_sel = 2'($urandom_range(0, 3));
            if (t % 4 == 3) begin
                {lock_a, lock_b, por_done, range_a, range_b} = 5'($urandom_range(0, 31));
                read_txn("R7 random");
            end else begin
                write_txn("R5 random", 8'($urandom_range(0, 11)), $urandom_range(1, 4),
                          8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
                check_bank("R5/R6 random bank");
            end
        end

        check("R10 sda stable while SCL high", r10_viol, 0);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule